// File: doc/BRIEF.md
# Packed Depth-Test Unit

This unit runs a depth-buffer comparison over two packed 64-bit operands in a single clock. A mode input splits each operand into lanes: two 32-bit lanes, or four 16-bit lanes. Lane 0 is always the least-significant lane. For every lane the unit keeps the unsigned minimum of the two source values. It also records a pass bit, which is 1 when the second operand's lane is no greater than the first operand's lane.

An 8-bit pass history is updated on each accepted operation. The older bits move toward bit 0 by the lane count, and the new pass bits go in at the top. A 64-bit merge accumulator sits alongside and is zeroed by every accepted operation. The minimum result is registered, while the history and the accumulator are readable at all times. When the strobe is low, nothing changes.

Top module: `zcheck_unit`

## Requirements
- R1: After reset, `result`, `pixMask` and `mergeAcc` are all zero.
- R2: With `inHalfMode`=0, each 32-bit lane of `result` holds the unsigned minimum of the matching lanes of `srcA` and `srcB`, and lane 0 is bits 31:0.
- R3: With `inHalfMode`=1, each 16-bit lane of `result` holds the unsigned minimum of the matching lanes of `srcA` and `srcB`, and lane 0 is bits 15:0.
- R4: With `inHalfMode`=0, the new `pixMask` is the old mask shifted right by 2. Bit 6+i then holds the pass bit of 32-bit lane i, for i in 0..1.
- R5: With `inHalfMode`=1, the new `pixMask` is the old mask shifted right by 4. Bit 4+i then holds the pass bit of 16-bit lane i, for i in 0..3.
- R6: A lane passes (bit 1) when its `srcB` value is less than or equal to its `srcA` value, compared unsigned. When the two values are equal the lane passes and the result lane takes that value.
- R7: Every accepted operation, in either mode, leaves `mergeAcc` equal to zero.
- R8: While `inValid` is 0, `result`, `pixMask` and `mergeAcc` keep their values whatever the other inputs do.
- R9: The result and mask of an operation accepted at a clock edge are visible right after that edge, one cycle after the inputs were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Accept the operation in this cycle |
| inHalfMode | input | 1 | 0: two 32-bit lanes, 1: four 16-bit lanes |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| result | output | 64 | Registered per-lane unsigned minimum |
| pixMask | output | 8 | Pass-bit history |
| mergeAcc | output | 64 | Merge accumulator |

## Verification
The hardest case to reach is a pass bit that travels the whole history. It is inserted at the top, shifted by both lane counts in turn, and can pause through idle cycles before it finally drops out of bit 0. The stimulus builds this with hand-written runs that alternate the two modes and put idle cycles with changing operands in between. A long pseudo-random stream follows, mixing the strobe, the mode and lane values. The bench's own model of the history predicts every bit in every cycle, and the equality and all-ones/zero lane values are driven on purpose.

// File: rtl/zchk_pkg.sv
`timescale 1ns/1ps
package zchk_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic shiftMask;
    logic clearMerge;
    logic halfMode;
  } zchkStrobes_t;
endpackage

// File: rtl/zchk_lane.sv
`timescale 1ns/1ps
module zchk_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  output logic [LANE_W-1:0] laneMin,
  output logic              lanePass
);
  // Pass when B does not exceed A (unsigned); ties pass
  always_comb begin
    lanePass = (laneB <= laneA);
    laneMin  = lanePass ? laneB : laneA;
  end
endmodule

// File: rtl/zchk_ctrl.sv
`timescale 1ns/1ps
module zchk_ctrl
  import zchk_pkg::*;
(
  input  logic         inValid,
  input  logic         inHalfMode,
  output zchkStrobes_t strobes
);
  always_comb begin
    strobes.loadResult = inValid;
    strobes.shiftMask  = inValid;
    strobes.clearMerge = inValid;
    strobes.halfMode   = inHalfMode;
  end
endmodule

// File: rtl/zchk_datapath.sv
`timescale 1ns/1ps
module zchk_datapath
  import zchk_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int MASK_W   = 8,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  zchkStrobes_t      strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [MASK_W-1:0] pixMask,
  output logic [DATA_W-1:0] mergeAcc
);
  localparam int WIDE_N   = DATA_W / WIDE_W;
  localparam int NARROW_N = DATA_W / NARROW_W;

  logic [DATA_W-1:0]   wideMin;
  logic [DATA_W-1:0]   narrowMin;
  logic [WIDE_N-1:0]   widePass;
  logic [NARROW_N-1:0] narrowPass;
  logic [DATA_W-1:0]   nextResult;
  logic [MASK_W-1:0]   nextMask;

  for (genvar g = 0; g < WIDE_N; g++) begin : gWide
    zchk_lane #(.LANE_W(WIDE_W)) uLane (
      .laneA   (srcA[g*WIDE_W +: WIDE_W]),
      .laneB   (srcB[g*WIDE_W +: WIDE_W]),
      .laneMin (wideMin[g*WIDE_W +: WIDE_W]),
      .lanePass(widePass[g])
    );
  end

  for (genvar g = 0; g < NARROW_N; g++) begin : gNarrow
    zchk_lane #(.LANE_W(NARROW_W)) uLane (
      .laneA   (srcA[g*NARROW_W +: NARROW_W]),
      .laneB   (srcB[g*NARROW_W +: NARROW_W]),
      .laneMin (narrowMin[g*NARROW_W +: NARROW_W]),
      .lanePass(narrowPass[g])
    );
  end

  // History: shift toward bit 0 by lane count, new pass bits enter at top
  always_comb begin
    if (strobes.halfMode) begin
      nextResult = narrowMin;
      nextMask   = {narrowPass, pixMask[MASK_W-1:NARROW_N]};
    end else begin
      nextResult = wideMin;
      nextMask   = {widePass, pixMask[MASK_W-1:WIDE_N]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      pixMask  <= '0;
      mergeAcc <= '0;
    end else begin
      if (strobes.loadResult) result   <= nextResult;
      if (strobes.shiftMask)  pixMask  <= nextMask;
      if (strobes.clearMerge) mergeAcc <= '0;
    end
  end
endmodule

// File: rtl/zcheck_unit.sv
`timescale 1ns/1ps
module zcheck_unit
  import zchk_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int MASK_W   = 8,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inHalfMode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [MASK_W-1:0] pixMask,
  output logic [DATA_W-1:0] mergeAcc
);
  zchkStrobes_t strobes;

  zchk_ctrl uCtrl (
    .inValid   (inValid),
    .inHalfMode(inHalfMode),
    .strobes   (strobes)
  );

  zchk_datapath #(
    .DATA_W  (DATA_W),
    .MASK_W  (MASK_W),
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .pixMask (pixMask),
    .mergeAcc(mergeAcc)
  );
endmodule

// File: rtl/zcheck_unit_chk.sv
`timescale 1ns/1ps
module zcheck_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inHalfMode,
  input logic [63:0] srcA,
  input logic [63:0] srcB,
  input logic [63:0] result,
  input logic [7:0]  pixMask,
  input logic [63:0] mergeAcc
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |-> (result == '0 && pixMask == '0 && mergeAcc == '0));

  a_r2_wide_low_min: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && !inHalfMode |=>
      result[31:0] <= $past(srcA[31:0]) && result[31:0] <= $past(srcB[31:0]));

  a_r3_narrow_top_min: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && inHalfMode |=>
      result[63:48] <= $past(srcA[63:48]) && result[63:48] <= $past(srcB[63:48]));

  a_r4_wide_shift: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && !inHalfMode |=> pixMask[5:0] == $past(pixMask[7:2]));

  a_r5_narrow_shift: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && inHalfMode |=> pixMask[3:0] == $past(pixMask[7:4]));

  a_r6_wide_lane1_pass: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid && !inHalfMode |=>
      pixMask[7] == ($past(srcB[63:32]) <= $past(srcA[63:32])));

  a_r7_merge_zero: assert property (@(posedge clk) disable iff (!rstN)
    rstN && inValid |=> mergeAcc == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !inValid |=> $stable(result) && $stable(pixMask) && $stable(mergeAcc));
endmodule

bind zcheck_unit zcheck_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inHalfMode(inHalfMode),
  .srcA      (srcA),
  .srcB      (srcB),
  .result    (result),
  .pixMask   (pixMask),
  .mergeAcc  (mergeAcc)
);

// File: tb/zcheck_unit_tb.sv
`timescale 1ns/1ps
module zcheck_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inHalfMode = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] result;
  logic [7:0]  pixMask;
  logic [63:0] mergeAcc;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] expRes;
    logic [7:0]  expMask;
    string       resTag;
    string       maskTag;
  } item_t;
  item_t sbq[$];

  // Bench-side model state
  logic [63:0] mRes = '0;
  logic [7:0]  mMask = '0;

  always #4 clk = ~clk;  // 125 MHz

  zcheck_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHalfMode(inHalfMode),
    .srcA(srcA), .srcB(srcB), .result(result), .pixMask(pixMask),
    .mergeAcc(mergeAcc)
  );

  task automatic check64(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: present one cycle of stimulus and push the predicted state
  task automatic issue(input bit v, input bit half, input logic [63:0] a,
                       input logic [63:0] b, input string extra);
    item_t it;
    int n;
    int w;
    @(negedge clk);
    inValid = v; inHalfMode = half; srcA = a; srcB = b;
    if (v) begin
      n = half ? 4 : 2;
      w = half ? 16 : 32;
      mMask = mMask >> n;
      for (int i = 0; i < n; i++) begin
        logic [31:0] la;
        logic [31:0] lb;
        la = 32'((a >> (i*w)) & ((64'd1 << w) - 1));
        lb = 32'((b >> (i*w)) & ((64'd1 << w) - 1));
        mMask[8-n+i] = (lb <= la);
        for (int k = 0; k < w; k++) mRes[i*w+k] = (lb <= la) ? lb[k] : la[k];
      end
      it.resTag  = {half ? "R3" : "R2", " R9", extra};
      it.maskTag = {half ? "R5" : "R4", " R9", extra};
    end else begin
      it.resTag  = "R8";
      it.maskTag = "R8";
    end
    it.expRes  = mRes;
    it.expMask = mMask;
    sbq.push_back(it);
  endtask

  // Monitor: sample after the edge that registered the driven cycle (R9)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check64(result == it.expRes, it.resTag, result, it.expRes);
        check64(pixMask == it.expMask, it.maskTag, {56'd0, pixMask}, {56'd0, it.expMask});
        check64(mergeAcc == '0, "R7", mergeAcc, 64'd0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check64(result == '0, "R1", result, 64'd0);
    check64(pixMask == '0, "R1", {56'd0, pixMask}, 64'd0);
    check64(mergeAcc == '0, "R1", mergeAcc, 64'd0);
    rstN = 1'b1;

    // 32-bit lanes: mixed pass/fail
    issue(1, 0, 64'h0000_0010_0000_0005, 64'h0000_0020_0000_0003, "");
    issue(1, 0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, "");
    // R6: equal lanes pass and keep the value
    issue(1, 0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, " R6");
    // R8: idle with changing operands
    issue(0, 1, 64'hDEAD_BEEF_0000_0001, 64'h0, "");
    issue(0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "");
    // 16-bit lanes: extremes and ties
    issue(1, 1, 64'hFFFF_0000_8000_0001, 64'h0000_FFFF_8000_0002, " R6");
    issue(1, 1, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, " R6");
    // History across mixed modes with idle gaps
    issue(1, 0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0000, "");
    issue(0, 1, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "");
    issue(1, 1, 64'h0000_FFFF_0000_FFFF, 64'h0001_0000_0001_0000, "");
    issue(1, 0, 64'h8000_0000_8000_0000, 64'h7FFF_FFFF_8000_0001, "");
    issue(1, 0, 64'h0, 64'h0, " R6");
    issue(1, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "");

    for (int i = 0; i < 300; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) b[31:16] = a[31:16];
      issue(($urandom % 4) != 0, $urandom % 2, a, b, "");
    end
    issue(0, 0, 64'h0, 64'h0, "");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule